// File: doc/BRIEF.md
# Converter Result Byte Port with Read Lock

This block takes a 10-bit converter result, delivered with a one-cycle completion strobe, and offers it to an 8-bit register read port as two bytes. A control input selects the alignment. In right alignment the two top result bits sit at the bottom of the high byte. In left alignment the top eight bits fill the high byte and the two lowest bits sit at the top of the low byte. Bits that carry no result bits read as zero.

To keep both bytes from the same conversion, reading the low byte locks the stored result. The lock stays until the high byte is read. A completion that arrives while the lock is set is discarded. The completion flag is still raised for that completion. The flag is cleared by writing one to it or by an acknowledge pulse. The interrupt line is the flag gated by an enable input.

Register map on the 2-bit address:
- 0: low byte.
- 1: high byte.
- 2: status, with the completion flag in bit 0.
- 3: unmapped.

Read data is registered and appears in the cycle after the read strobe. Reset is synchronous and active high.

Top module: `adc_result_port`

## Requirements
- R1: After reset the low byte, high byte and status all read 0, the irq output is 0 and the lock is clear.
- R2: With left_align low, address 1 reads {000000, result[9:8]} and address 0 reads result[7:0].
- R3: With left_align high, address 1 reads result[9:2] and address 0 reads {result[1:0], 000000}.
- R4: Reading only the high byte (address 1) never sets the lock, so a later result is visible at the next high-byte read.
- R5: A read of address 0 sets the lock. While the lock is set, an arriving result changes neither byte and is lost.
- R6: A read of address 1 clears the lock, and later results update both bytes again. A result in the same cycle as that unlocking read is still dropped.
- R7: Every completion strobe sets status bit 0, including a strobe whose result was dropped. The irq output equals status bit 0 AND irq_en.
- R8: Status bit 0 is cleared by a write to address 2 with wdata bit 0 set, or by an irq_ack pulse. A completion strobe in the same cycle as a clear leaves the flag set.
- R9: A completion strobe in the same cycle as an unlocked address-0 read is stored first, so that read returns the new low byte. The lock is set afterwards, which drops the next result.
- R10: A read of the unmapped address 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| res_valid | input | 1 | One-cycle completion strobe |
| res_data | input | 10 | Conversion result |
| left_align | input | 1 | 1 selects left alignment |
| irq_en | input | 1 | Interrupt enable |
| irq_ack | input | 1 | Interrupt acknowledge pulse, clears the flag |
| rd_stb | input | 1 | Read strobe |
| wr_stb | input | 1 | Write strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data (bit 0 used at address 2) |
| rdata | output | 8 | Registered read data, valid the cycle after rd_stb |
| irq | output | 1 | Completion interrupt |

## Verification
Two pairs of functions can meet in one cycle.

The first pair is the storage of a new result and the low-byte read that sets the lock. The bench drives the strobe and the address-0 read in the same cycle. It expects the new low byte back, and it expects the following result to be dropped.

The second pair is setting and clearing the flag. The bench pairs a completion strobe with an acknowledge pulse, and separately with a write-one clear. In both cases it expects the flag to read as set afterwards.

// File: rtl/adc_rp_pkg.sv
package adc_rp_pkg;
  localparam logic [1:0] ADR_LO   = 2'd0;
  localparam logic [1:0] ADR_HI   = 2'd1;
  localparam logic [1:0] ADR_STAT = 2'd2;
endpackage

// File: rtl/adc_result_store.sv
module adc_result_store #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             res_valid,
  input  logic [RES_W-1:0] res_data,
  input  logic             rd_lo,
  input  logic             rd_hi,
  output logic [RES_W-1:0] res_q,
  output logic [RES_W-1:0] res_view,
  output logic             lock_q
);
  logic accept;
  assign accept   = res_valid && !lock_q;
  // a read in the same cycle as an accepted result sees the new value
  assign res_view = accept ? res_data : res_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q  <= '0;
      lock_q <= 1'b0;
    end else begin
      if (accept) res_q <= res_data;
      if (rd_lo)      lock_q <= 1'b1;
      else if (rd_hi) lock_q <= 1'b0;
    end
  end

  assert_locked_hold_R5: assert property (@(posedge clk) disable iff (rst)
    lock_q |=> $stable(res_q));
  assert_lo_read_locks_R5: assert property (@(posedge clk) disable iff (rst)
    rd_lo |=> lock_q);
  assert_hi_read_unlocks_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_hi && !rd_lo) |=> !lock_q);
  assert_accept_stores_R9: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !lock_q) |=> (res_q == $past(res_data)));
endmodule

// File: rtl/adc_byte_align.sv
module adc_byte_align #(
  parameter int RES_W  = 10,
  parameter int BYTE_W = 8
) (
  input  logic [RES_W-1:0]  res,
  input  logic              left_align,
  output logic [BYTE_W-1:0] lo_byte,
  output logic [BYTE_W-1:0] hi_byte
);
  localparam int FULL_W = 2 * BYTE_W;
  localparam int PAD_W  = FULL_W - RES_W;

  logic [FULL_W-1:0] right_v, left_v, sel_v;
  assign right_v = {{PAD_W{1'b0}}, res};
  assign left_v  = {res, {PAD_W{1'b0}}};
  assign sel_v   = left_align ? left_v : right_v;
  assign lo_byte = sel_v[BYTE_W-1:0];
  assign hi_byte = sel_v[FULL_W-1:BYTE_W];

  always_comb begin
    if (!left_align)
      assert_right_pad_zero_R2: assert (hi_byte[BYTE_W-1:RES_W-BYTE_W] == '0);
    else
      assert_left_pad_zero_R3: assert (lo_byte[PAD_W-1:0] == '0);
  end
endmodule

// File: rtl/adc_irq_flag.sv
module adc_irq_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_q
);
  always_ff @(posedge clk) begin
    if (rst)        flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
    set_i |=> flag_q);
  assert_clear_works_R8: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !flag_q);
endmodule

// File: rtl/adc_result_port.sv
module adc_result_port
  import adc_rp_pkg::*;
#(
  parameter int RES_W  = 10,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              res_valid,
  input  logic [RES_W-1:0]  res_data,
  input  logic              left_align,
  input  logic              irq_en,
  input  logic              irq_ack,
  input  logic              rd_stb,
  input  logic              wr_stb,
  input  logic [1:0]        addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  output logic              irq
);
  logic rd_lo, rd_hi, flag_clr, flag_q, lock_q;
  logic [RES_W-1:0]  res_q, res_view;
  logic [BYTE_W-1:0] lo_byte, hi_byte, rdata_d;
  logic              unused_wbits;

  assign rd_lo        = rd_stb && (addr == ADR_LO);
  assign rd_hi        = rd_stb && (addr == ADR_HI);
  assign flag_clr     = irq_ack || (wr_stb && (addr == ADR_STAT) && wdata[0]);
  assign unused_wbits = ^wdata[BYTE_W-1:1];

  adc_result_store #(.RES_W(RES_W)) u_store (
    .clk(clk), .rst(rst), .res_valid(res_valid), .res_data(res_data),
    .rd_lo(rd_lo), .rd_hi(rd_hi), .res_q(res_q), .res_view(res_view),
    .lock_q(lock_q)
  );

  adc_byte_align #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_align (
    .res(res_view), .left_align(left_align),
    .lo_byte(lo_byte), .hi_byte(hi_byte)
  );

  adc_irq_flag u_flag (
    .clk(clk), .rst(rst), .set_i(res_valid), .clr_i(flag_clr), .flag_q(flag_q)
  );

  always_comb begin
    case (addr)
      ADR_LO:   rdata_d = lo_byte;
      ADR_HI:   rdata_d = hi_byte;
      ADR_STAT: rdata_d = {{(BYTE_W-1){1'b0}}, flag_q};
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata <= '0;
    else if (rd_stb) rdata <= rdata_d;
  end

  assign irq = flag_q && irq_en;

  assert_flag_on_done_R7: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> (irq == irq_en));
  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && addr == 2'd3) |=> (rdata == '0));
  assert_drop_when_locked_R5: assert property (@(posedge clk) disable iff (rst)
    (res_valid && lock_q) |=> (res_q == $past(res_q)));
endmodule

// File: tb/adc_result_port_bench.sv
module adc_result_port_bench;
  logic clk = 0, rst = 1;
  logic res_valid = 0, left_align = 0, irq_en = 0, irq_ack = 0;
  logic rd_stb = 0, wr_stb = 0;
  logic [9:0] res_data = '0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0, rdata, d;
  logic irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  adc_result_port u_adc_result_port (
    .clk(clk), .rst(rst), .res_valid(res_valid), .res_data(res_data),
    .left_align(left_align), .irq_en(irq_en), .irq_ack(irq_ack),
    .rd_stb(rd_stb), .wr_stb(wr_stb), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq(irq)
  );

  function automatic logic [7:0] exp_byte(logic [9:0] v, logic left, logic hi);
    if (!left) return hi ? {6'b0, v[9:8]} : v[7:0];
    else       return hi ? v[9:2] : {v[1:0], 6'b0};
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic push(logic [9:0] v);
    @(negedge clk); res_valid = 1; res_data = v;
    @(negedge clk); res_valid = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] o);
    @(negedge clk); rd_stb = 1; addr = a;
    @(negedge clk); rd_stb = 0; o = rdata;
  endtask

  task automatic wclear(logic with_push, logic [9:0] v);
    @(negedge clk); wr_stb = 1; addr = 2'd2; wdata = 8'h01;
    res_valid = with_push; res_data = v;
    @(negedge clk); wr_stb = 0; res_valid = 0;
  endtask

  task automatic ack(logic with_push, logic [9:0] v);
    @(negedge clk); irq_ack = 1; res_valid = with_push; res_data = v;
    @(negedge clk); irq_ack = 0; res_valid = 0;
  endtask

  task automatic t_reset;
    check("R1 irq", {7'b0, irq}, 8'h00);
    rd(2'd0, d); check("R1 low", d, 8'h00);
    rd(2'd1, d); check("R1 high", d, 8'h00);
    rd(2'd2, d); check("R1 status", d, 8'h00);
  endtask

  task automatic t_right;
    logic [9:0] vals [3] = '{10'h2A5, 10'h3FF, 10'h100};
    left_align = 0;
    foreach (vals[i]) begin
      push(vals[i]);
      rd(2'd0, d); check("R2 low", d, exp_byte(vals[i], 0, 0));
      rd(2'd1, d); check("R2 high", d, exp_byte(vals[i], 0, 1));
    end
  endtask

  task automatic t_left;
    left_align = 1;
    push(10'h2A5);
    rd(2'd0, d); check("R3 low", d, 8'h40);
    rd(2'd1, d); check("R3 high", d, 8'hA9);
    push(10'h3FF);
    rd(2'd0, d); check("R3 low ones", d, 8'hC0);
    rd(2'd1, d); check("R3 high ones", d, 8'hFF);
    push(10'h155);
    rd(2'd1, d); check("R4 high only", d, exp_byte(10'h155, 1, 1));
    push(10'h0AA);
    rd(2'd1, d); check("R4 no lock", d, exp_byte(10'h0AA, 1, 1));
    left_align = 0;
  endtask

  task automatic t_lock;
    push(10'h123);
    rd(2'd0, d); check("R5 low", d, 8'h23);
    ack(0, '0);
    push(10'h2EE);
    rd(2'd2, d); check("R7 flag on dropped", d, 8'h01);
    rd(2'd1, d); check("R5 high kept", d, 8'h01);
    rd(2'd0, d); check("R5 low kept", d, 8'h23);
    // high read together with a strobe: lock still holds that cycle
    @(negedge clk); rd_stb = 1; addr = 2'd1; res_valid = 1; res_data = 10'h3C3;
    @(negedge clk); rd_stb = 0; res_valid = 0;
    check("R6 same-cycle drop", rdata, 8'h01);
    rd(2'd0, d); check("R6 still old", d, 8'h23);
    rd(2'd1, d);
    push(10'h2F0);
    rd(2'd0, d); check("R6 updates low", d, 8'hF0);
    rd(2'd1, d); check("R6 updates high", d, 8'h02);
  endtask

  task automatic t_irq;
    ack(0, '0);
    irq_en = 0; push(10'h001);
    check("R7 gated", {7'b0, irq}, 8'h00);
    rd(2'd2, d); check("R7 flag", d, 8'h01);
    irq_en = 1; #1;
    check("R7 irq", {7'b0, irq}, 8'h01);
    wclear(0, '0);
    rd(2'd2, d); check("R8 write clear", d, 8'h00);
    check("R8 irq low", {7'b0, irq}, 8'h00);
    push(10'h002); ack(0, '0);
    rd(2'd2, d); check("R8 ack clear", d, 8'h00);
    ack(1, 10'h003);
    rd(2'd2, d); check("R8 set beats ack", d, 8'h01);
    wclear(1, 10'h004);
    rd(2'd2, d); check("R8 set beats write", d, 8'h01);
    check("R7 irq after", {7'b0, irq}, 8'h01);
    ack(0, '0); irq_en = 0;
  endtask

  task automatic t_same;
    @(negedge clk); res_valid = 1; res_data = 10'h1B7; rd_stb = 1; addr = 2'd0;
    @(negedge clk); res_valid = 0; rd_stb = 0;
    check("R9 new low", rdata, 8'hB7);
    push(10'h3AA);
    rd(2'd1, d); check("R9 locked after", d, 8'h01);
  endtask

  task automatic t_unmapped;
    push(10'h3FF);
    rd(2'd3, d); check("R10 unmapped", d, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_right();
    t_left();
    t_lock();
    t_irq();
    t_same();
    t_unmapped();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule